// File: doc/BRIEF.md
# Panel Command Stream Player

The player walks a packed byte stream of display-panel set-up commands held in a byte-wide memory. It issues reads on a simple synchronous read port, pulls apart each variable-length record and offers one command per record to a downstream sink. After the sink accepts a command, the player pauses for the number of milliseconds the record requests. It counts these milliseconds as pulses of an external 1 ms tick.

A record is a three-byte header followed by its payload. The header holds the command data type, then the delay in milliseconds, then the payload length. At most the first two payload bytes are forwarded. Any further payload bytes are stepped over. A pulse on `start` latches the stream length and the mode and plays the stream from address zero. The player raises `done` for one cycle once the stream is used up, or raises `error` for one cycle if packet mode meets an unknown data type.

The command output is a valid/ready interface. `cmd_valid` rises with the command fields, and the fields stay frozen for as long as `cmd_ready` stays low. The transfer takes place on the first rising edge at which both signals are high, and the sink may hold `cmd_ready` low for as long as it needs. The memory port uses no handshake. When `mem_rd` is high at a rising edge, the byte at `mem_addr` must appear on `mem_data` in the following cycle.

Top module: `panel_cmd_player`

## Requirements
- R1: After reset `cmd_valid`, `done`, `error` and `mem_rd` are low.
- R2: A record at offset p has its data type at p, its delay at p+1, its payload length L at p+2 and its payload from p+3. The next record starts at p+3+L. Records are offered in stream order.
- R3: If L is 2, `cmd_value` is {first payload byte, second payload byte}. If L is 1 or greater than 2, it is {8'h00, first payload byte}. If L is 0, it is 16'h0000. `cmd_plen` carries L unchanged and `cmd_type` carries the data type.
- R4: A record is parsed only while the stream length minus p is greater than 3. A shorter tail yields no command. A stream of length 0 to 3 yields `done` and no command.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_type`, `cmd_value` and `cmd_plen` hold their values.
- R6: When a record with delay d > 0 is accepted, nothing further is offered and `done` is not raised until d tick pulses have been seen after the accepting edge. A tick in the accepting cycle does not count. A delay of 0 needs no tick.
- R7: When `pkt_mode` is latched high, the supported data types are 0x03, 0x13, 0x23, 0x29, 0x05, 0x15 and 0x39. Any other type raises `error` for exactly one cycle, offers no command for that record, ends the run and raises no `done`. When `pkt_mode` is latched low, every type is forwarded.
- R8: `done` is high for exactly one cycle after the last command has been accepted and its delay has elapsed. It is never high together with `error`.
- R9: A `start` pulse while a run is in progress is ignored. The run continues unchanged and gives one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin playing a stream (ignored while busy) |
| pkt_mode | input | 1 | 1: reject unsupported data types; latched on start |
| stream_len | input | ADDR_W+1 | Stream length in bytes; latched on start |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| mem_rd | output | 1 | Read strobe to the stream memory |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_data | input | 8 | Read byte, valid the cycle after `mem_rd` |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Sink accepts the command |
| cmd_type | output | 8 | Command data type |
| cmd_value | output | 16 | Forwarded payload bytes |
| cmd_plen | output | 8 | Payload length from the header |
| done | output | 1 | One-cycle pulse at the end of the stream |
| error | output | 1 | One-cycle pulse on a rejected data type |

## Verification
The bench builds the player with ADDR_W = 8. A 256-byte memory then holds every stream the tests need, and the stream length port is nine bits wide. The millisecond tick is generated every ten clocks, so delays of a few milliseconds finish in tens of cycles. This makes it possible to check the bounds of the tick count between accepted commands. It also allows a second start to land in the middle of a delay. Some streams run with the tick held low, which shows that zero-delay records never wait for a tick.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int PM_BYTE_W = 8;
  localparam int PM_HDR_BYTES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_CAPTURE,
    ST_DECODE,
    ST_OFFER,
    ST_WAIT
  } pm_state_t;
endpackage

// File: rtl/pm_byte_reader.sv
module pm_byte_reader #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic              rvalid,
  output logic [7:0]        rdata
);
  assign mem_rd   = req;
  assign mem_addr = addr;
  assign rdata    = mem_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= req;
  end
endmodule

// File: rtl/pm_type_gate.sv
module pm_type_gate (
  input  logic [7:0] dtype,
  output logic       supported
);
  always_comb begin
    unique case (dtype)
      8'h03, 8'h13, 8'h23, 8'h29,
      8'h05, 8'h15, 8'h39: supported = 1'b1;
      default:             supported = 1'b0;
    endcase
  end
endmodule

// File: rtl/pm_ms_timer.sv
module pm_ms_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (tick && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/panel_cmd_player.sv
module panel_cmd_player
  import pm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pkt_mode,
  input  logic [ADDR_W:0]   stream_len,
  input  logic              ms_tick,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_type,
  output logic [15:0]       cmd_value,
  output logic [7:0]        cmd_plen,
  output logic              done,
  output logic              error
);
  localparam int POS_W = ADDR_W + 10;

  pm_state_t          st_q;
  logic [POS_W-1:0]   pos_q;
  logic [ADDR_W:0]    len_q;
  logic               mode_q;
  logic [2:0]         idx_q;
  logic [PM_BYTE_W-1:0] typ_q, dly_q, plen_q, p0_q, p1_q;
  logic               valid_q, done_q, error_q;
  logic [7:0]         otype_q, oplen_q;
  logic [15:0]        ovalue_q;

  logic               rd_req, rd_valid;
  logic [ADDR_W-1:0]  rd_addr;
  logic [7:0]         rd_data;
  logic               type_ok, dly_busy, dly_load;
  logic               more;
  logic [POS_W-1:0]   step;

  assign rd_req  = (st_q == ST_ISSUE);
  assign rd_addr = pos_q[ADDR_W-1:0] + ADDR_W'(idx_q);
  assign more    = (POS_W'(len_q) >= pos_q + POS_W'(PM_HDR_BYTES + 1));
  assign step    = POS_W'(plen_q) + POS_W'(PM_HDR_BYTES);
  assign dly_load = (st_q == ST_OFFER) && cmd_ready && (dly_q != '0);

  pm_byte_reader #(.ADDR_W(ADDR_W)) u_reader (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (rd_req),
    .addr     (rd_addr),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .rvalid   (rd_valid),
    .rdata    (rd_data)
  );

  pm_type_gate u_gate (
    .dtype     (typ_q),
    .supported (type_ok)
  );

  pm_ms_timer #(.CNT_W(PM_BYTE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (dly_q),
    .tick     (ms_tick),
    .busy     (dly_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pos_q    <= '0;
      len_q    <= '0;
      mode_q   <= 1'b0;
      idx_q    <= '0;
      typ_q    <= '0;
      dly_q    <= '0;
      plen_q   <= '0;
      p0_q     <= '0;
      p1_q     <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
      error_q  <= 1'b0;
      otype_q  <= '0;
      oplen_q  <= '0;
      ovalue_q <= '0;
    end else begin
      done_q  <= 1'b0;
      error_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            len_q  <= stream_len;
            mode_q <= pkt_mode;
            pos_q  <= '0;
            st_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (more) begin
            idx_q <= '0;
            st_q  <= ST_ISSUE;
          end else begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_ISSUE: st_q <= ST_CAPTURE;
        ST_CAPTURE: begin
          if (rd_valid) begin
            st_q  <= ST_ISSUE;
            idx_q <= idx_q + 3'd1;
            unique case (idx_q)
              3'd0: typ_q <= rd_data;
              3'd1: dly_q <= rd_data;
              3'd2: begin
                plen_q <= rd_data;
                if (rd_data == '0) st_q <= ST_DECODE;
              end
              3'd3: begin
                p0_q <= rd_data;
                if (plen_q < 8'd2) st_q <= ST_DECODE;
              end
              default: begin
                p1_q <= rd_data;
                st_q <= ST_DECODE;
              end
            endcase
          end
        end
        ST_DECODE: begin
          if (mode_q && !type_ok) begin
            error_q <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            otype_q <= typ_q;
            oplen_q <= plen_q;
            if (plen_q == 8'd2)      ovalue_q <= {p0_q, p1_q};
            else if (plen_q == 8'd0) ovalue_q <= 16'h0000;
            else                     ovalue_q <= {8'h00, p0_q};
            valid_q <= 1'b1;
            st_q    <= ST_OFFER;
          end
        end
        ST_OFFER: begin
          if (cmd_ready) begin
            valid_q <= 1'b0;
            pos_q   <= pos_q + step;
            st_q    <= (dly_q != '0) ? ST_WAIT : ST_CHECK;
          end
        end
        ST_WAIT: begin
          if (!dly_busy) st_q <= ST_CHECK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_type  = otype_q;
  assign cmd_value = ovalue_q;
  assign cmd_plen  = oplen_q;
  assign done      = done_q;
  assign error     = error_q;
endmodule

// File: rtl/panel_cmd_player_chk.sv
module panel_cmd_player_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_type,
  input logic [15:0] cmd_value,
  input logic [7:0]  cmd_plen,
  input logic        done,
  input logic        error
);
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid); // R5
  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> $stable(cmd_type) && $stable(cmd_value) && $stable(cmd_plen)); // R5
  AST_NO_READ_WHILE_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !mem_rd); // R2
  AST_ACCEPT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid); // R6
  AST_VALUE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_plen != 8'd2 |-> cmd_value[15:8] == 8'h00); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ERROR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error); // R7
  AST_DONE_ERROR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R8
endmodule

bind panel_cmd_player panel_cmd_player_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd    (mem_rd),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_type  (cmd_type),
  .cmd_value (cmd_value),
  .cmd_plen  (cmd_plen),
  .done      (done),
  .error     (error)
);

// File: tb/panel_cmd_player_test.sv
module panel_cmd_player_test;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              pkt_mode = 1'b0;
  logic [ADDR_W:0]   stream_len = '0;
  logic              ms_tick = 1'b0;
  logic              mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_data = '0;
  logic              cmd_valid;
  logic              cmd_ready = 1'b1;
  logic [7:0]        cmd_type;
  logic [15:0]       cmd_value;
  logic [7:0]        cmd_plen;
  logic              done, error;

  int checks = 0, errors = 0;
  logic [7:0] rom [0:255];
  int wp = 0;
  bit tick_en = 1'b0;
  int div = 0;

  int n_acc = 0, done_cnt = 0, err_cnt = 0, tk = 0, tk_done = 0;
  int lt [0:15];
  int lv [0:15];
  int lp [0:15];
  int gap [0:15];

  always #(CLK_P/2) clk = ~clk;

  panel_cmd_player #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_mode(pkt_mode),
    .stream_len(stream_len), .ms_tick(ms_tick), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_type(cmd_type), .cmd_value(cmd_value),
    .cmd_plen(cmd_plen), .done(done), .error(error)
  );

  always @(posedge clk) if (mem_rd) mem_data <= rom[mem_addr];

  initial forever begin
    @(posedge clk); #1;
    ms_tick = tick_en && (div == 9);
    div = (div == 9) ? 0 : div + 1;
  end

  always @(negedge clk) begin
    if (ms_tick) tk++;
    if (cmd_valid && cmd_ready && n_acc < 16) begin
      lt[n_acc] = cmd_type; lv[n_acc] = cmd_value; lp[n_acc] = cmd_plen;
      gap[n_acc] = tk; tk = 0; n_acc++;
    end
    if (done)  begin done_cnt++; tk_done = tk; end
    if (error) err_cnt++;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P*150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input int b);
    rom[wp] = b[7:0]; wp++;
  endtask

  task automatic rec(input int t, input int d, input int pl, input int b0, input int b1, input int b2, input int b3);
    put(t); put(d); put(pl);
    if (pl > 0) put(b0);
    if (pl > 1) put(b1);
    if (pl > 2) put(b2);
    if (pl > 3) put(b3);
  endtask

  task automatic launch(input int len, input bit mode);
    n_acc = 0; done_cnt = 0; err_cnt = 0; tk = 0; tk_done = 0;
    @(posedge clk); #1;
    stream_len = len[ADDR_W:0]; pkt_mode = mode; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_end(input int max_cyc);
    int c = 0;
    while (done_cnt == 0 && err_cnt == 0 && c < max_cyc) begin
      @(posedge clk); c++;
    end
    repeat (30) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_valid == 0, "R1", "cmd_valid", cmd_valid, 0);
    chk(done == 0 && error == 0, "R1", "done/error", {done, error}, 0);
    chk(mem_rd == 0, "R1", "mem_rd", mem_rd, 0);
  endtask

  task automatic t_basic();
    wp = 0; tick_en = 0; cmd_ready = 1;
    rec(8'h15, 0, 2, 8'h11, 8'h22, 0, 0);
    rec(8'h05, 0, 1, 8'h29, 0, 0, 0);
    rec(8'h03, 0, 0, 0, 0, 0, 0);
    rec(8'h39, 0, 4, 8'hAA, 8'hBB, 8'hCC, 8'hDD);
    put(8'h77); put(8'h01); put(8'h00);
    launch(wp, 1'b1);
    wait_end(2000);
    chk(n_acc == 4, "R4", "commands (tail dropped)", n_acc, 4);
    chk(lt[0] == 8'h15 && lv[0] == 16'h1122 && lp[0] == 2, "R3", "two-byte value", lv[0], 16'h1122);
    chk(lt[1] == 8'h05 && lv[1] == 16'h0029 && lp[1] == 1, "R2", "second record", lv[1], 16'h0029);
    chk(lt[2] == 8'h03 && lv[2] == 0 && lp[2] == 0, "R3", "empty payload", lv[2], 0);
    chk(lt[3] == 8'h39 && lv[3] == 16'h00AA && lp[3] == 4, "R2", "long payload skip", lv[3], 16'h00AA);
    chk(done_cnt == 1 && err_cnt == 0, "R6", "zero delay done without ticks", done_cnt, 1);
    chk(err_cnt == 0, "R7", "supported types pass", err_cnt, 0);
  endtask

  task automatic t_short();
    wp = 0; tick_en = 0;
    rec(8'h15, 0, 1, 8'h01, 0, 0, 0);
    launch(0, 1'b0);
    wait_end(200);
    chk(n_acc == 0 && done_cnt == 1, "R4", "empty stream", n_acc, 0);
    launch(3, 1'b0);
    wait_end(200);
    chk(n_acc == 0 && done_cnt == 1, "R4", "three-byte stream", n_acc, 0);
    launch(4, 1'b0);
    wait_end(200);
    chk(n_acc == 1 && lv[0] == 16'h0001, "R4", "four-byte stream", n_acc, 1);
  endtask

  task automatic t_backpressure();
    int ty, va, pl;
    bit ok = 1;
    wp = 0; tick_en = 0; cmd_ready = 0;
    rec(8'h15, 0, 2, 8'hC3, 8'h5A, 0, 0);
    launch(wp, 1'b1);
    while (!cmd_valid) @(negedge clk);
    ty = cmd_type; va = cmd_value; pl = cmd_plen;
    repeat (6) begin
      @(negedge clk);
      if (!(cmd_valid && cmd_type == ty && cmd_value == va && cmd_plen == pl)) ok = 0;
    end
    chk(ok, "R5", "held under back-pressure", cmd_value, va);
    chk(done_cnt == 0, "R5", "no done while stalled", done_cnt, 0);
    @(posedge clk); #1; cmd_ready = 1;
    wait_end(500);
    chk(n_acc == 1 && lv[0] == 16'hC35A, "R5", "accepted after release", lv[0], 16'hC35A);
  endtask

  task automatic t_delay();
    wp = 0; tick_en = 1; cmd_ready = 1;
    rec(8'h05, 3, 1, 8'h10, 0, 0, 0);
    rec(8'h05, 2, 1, 8'h20, 0, 0, 0);
    launch(wp, 1'b1);
    wait_end(3000);
    chk(n_acc == 2, "R6", "commands", n_acc, 2);
    chk(gap[1] >= 3 && gap[1] <= 5, "R6", "ticks before second", gap[1], 3);
    chk(tk_done >= 2 && tk_done <= 4, "R8", "ticks before done", tk_done, 2);
    chk(done_cnt == 1, "R8", "done cycles", done_cnt, 1);
    tick_en = 0;
  endtask

  task automatic t_mode();
    wp = 0; tick_en = 0; cmd_ready = 1;
    rec(8'h15, 0, 1, 8'h01, 0, 0, 0);
    rec(8'h44, 0, 1, 8'h02, 0, 0, 0);
    rec(8'h05, 0, 1, 8'h03, 0, 0, 0);
    launch(wp, 1'b1);
    wait_end(2000);
    chk(n_acc == 1, "R7", "commands before reject", n_acc, 1);
    chk(err_cnt == 1, "R7", "error cycles", err_cnt, 1);
    chk(done_cnt == 0, "R7", "no done after error", done_cnt, 0);
    launch(wp, 1'b0);
    wait_end(2000);
    chk(n_acc == 3 && lt[1] == 8'h44, "R7", "raw mode forwards any type", lt[1], 8'h44);
    chk(err_cnt == 0 && done_cnt == 1, "R7", "raw mode completes", done_cnt, 1);
  endtask

  task automatic t_busy_start();
    wp = 0; tick_en = 1; cmd_ready = 1;
    rec(8'h05, 2, 1, 8'h41, 0, 0, 0);
    rec(8'h05, 0, 1, 8'h42, 0, 0, 0);
    launch(wp, 1'b0);
    while (n_acc == 0) @(posedge clk);
    #1 start = 1;
    @(posedge clk); #1 start = 0;
    wait_end(3000);
    chk(n_acc == 2 && lv[1] == 16'h0042, "R9", "run unaffected", n_acc, 2);
    chk(done_cnt == 1, "R9", "single done", done_cnt, 1);
    tick_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
    t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_short();
    t_backpressure();
    t_delay();
    t_mode();
    t_busy_start();
    summary();
  end
endmodule